// File: doc/BRIEF.md
# Cascaded Synchronous BCD Down-Counter

This block counts down in decimal across a chain of four-bit BCD digits, two by default. Every digit register is clocked by the same clock. The digit stages are linked only through count enables. A stage that sits at zero while its own enable is high raises a terminal-count flag. That flag is the enable of the next higher stage. On the same edge, the zero stage reloads nine and the next stage takes one step. So the count 20 is held for a full clock period before 19, like every other value, and no intermediate value ever shows up.

One active-low control both presets and resets the counter. It acts only at a clock edge. A pulse that starts and ends between two edges is never seen. A power-up reset therefore has to stay low across at least one rising edge. The whole-counter terminal count is high while every digit is zero and counting is enabled. The next enabled edge then wraps the counter to all nines. Software or a higher-level sequencer uses this flag to detect the end of a countdown.

The control and status pins are plain levels. There is no data stream and no handshake.

Top module: `bcd_dncount`

## Requirements
- R1: While load_n is low at a rising edge, each digit takes its four-bit slice of preset. Digit k uses preset[4k+3:4k], and the low digit is in bits 3:0. This happens whatever cnt_en is: load wins over counting.
- R2: load_n is sampled only at rising edges. A low pulse that begins and ends between two edges leaves count unchanged.
- R3: With load_n high and cnt_en low, every digit holds its value, and preset is ignored.
- R4: With load_n high and cnt_en high, the low digit steps down by one on each edge, from 9 to 0. From 0 it goes back to 9.
- R5: A higher digit steps only on an edge where every lower digit is 0 and cnt_en is high. On that same edge the lower digits reload 9. Starting from 29, the outputs are 29, 28, ... 21, 20, 19, each held for exactly one cycle.
- R6: When all digits are 0 and the counter is enabled, the next edge gives all nines (00 to 99 for two digits).
- R7: term_cnt is high exactly when cnt_en is high and every digit is 0. It follows cnt_en within the same cycle.
- R8: A digit loaded with a value above 9 goes to 9 on its next enabled step. Such a digit does not count as zero, so it does not enable the digit above it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for every digit stage |
| load_n | input | 1 | Active-low synchronous preset/reset |
| cnt_en | input | 1 | Global count enable |
| preset | input | 4*DIGITS | Preset values, low digit in bits 3:0 |
| count | output | 4*DIGITS | Current BCD digits, low digit in bits 3:0 |
| term_cnt | output | 1 | All digits zero while counting is enabled |

## Verification
The bench builds the counter with DIGITS = 2, which is the default. At that width the whole 100-state cycle, including the 00 to 99 wrap and the 20 to 19 carry edge, is reached within a hundred enabled cycles. Directed steps cover digit presets above nine in each position, load pulses between edges, and load applied together with the enable. A long stretch of random load, enable and preset values is then compared cycle by cycle with a behavioural integer model.

// File: rtl/bcd_dn_pkg.sv
`timescale 1ns/1ps
package bcd_dn_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DIGIT_TOP = 4'd9;

  typedef logic [DIGIT_W-1:0] digit_t;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_STEP = 2'd2
  } digit_act_e;
endpackage

// File: rtl/bcd_digit_next.sv
`timescale 1ns/1ps
module bcd_digit_next
  import bcd_dn_pkg::*;
(
  input  digit_t     cur,
  input  digit_t     preset,
  input  logic       load_n,
  input  logic       step_en,
  output digit_t     nxt,
  output digit_act_e act
);
  // Load outranks counting; counting outranks holding.
  always_comb begin
    if (!load_n)      act = ACT_LOAD;
    else if (step_en) act = ACT_STEP;
    else              act = ACT_HOLD;
  end

  always_comb begin
    unique case (act)
      ACT_LOAD: nxt = preset;
      // Zero wraps to nine; an illegal code is pulled back to nine.
      ACT_STEP: nxt = ((cur == '0) || (cur > DIGIT_TOP)) ? DIGIT_TOP : digit_t'(cur - 1'b1);
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/bcd_digit_stage.sv
`timescale 1ns/1ps
module bcd_digit_stage
  import bcd_dn_pkg::*;
(
  input  logic   clk,
  input  logic   load_n,
  input  logic   step_en,
  input  digit_t preset,
  output digit_t value,
  output logic   tc
);
  digit_t     nxt;
  digit_act_e act;

  bcd_digit_next u_next (
    .cur     (value),
    .preset  (preset),
    .load_n  (load_n),
    .step_en (step_en),
    .nxt     (nxt),
    .act     (act)
  );

  always_ff @(posedge clk) begin
    value <= nxt;
  end

  // Terminal count comes from the registered digit and the enable, so it settles once per cycle.
  assign tc = step_en && (value == '0);

  // R4
  zero_wrap_chk: assert property (@(posedge clk) disable iff (!load_n)
    (act == ACT_STEP) && (value == '0) |=> value == DIGIT_TOP);

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (!load_n)
    step_en && (value != '0) && (value <= DIGIT_TOP) |=> value == digit_t'($past(value) - 1'b1));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!load_n)
    !step_en |=> $stable(value));

  // R8
  range_fix_chk: assert property (@(posedge clk) disable iff (!load_n)
    step_en && (value > DIGIT_TOP) |=> value == DIGIT_TOP);
endmodule

// File: rtl/bcd_dncount.sv
`timescale 1ns/1ps
module bcd_dncount
  import bcd_dn_pkg::*;
#(
  parameter int DIGITS = 2
) (
  input  logic                      clk,
  input  logic                      load_n,
  input  logic                      cnt_en,
  input  logic [DIGITS*DIGIT_W-1:0] preset,
  output logic [DIGITS*DIGIT_W-1:0] count,
  output logic                      term_cnt
);
  localparam int TOTAL_W = DIGITS * DIGIT_W;
  localparam logic [TOTAL_W-1:0] ALL_NINES = {DIGITS{DIGIT_TOP}};

  // en_chain[k] enables digit k; en_chain[k+1] is digit k's terminal count.
  logic [DIGITS:0] en_chain;
  assign en_chain[0] = cnt_en;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    bcd_digit_stage u_stage (
      .clk     (clk),
      .load_n  (load_n),
      .step_en (en_chain[g]),
      .preset  (preset[g*DIGIT_W +: DIGIT_W]),
      .value   (count[g*DIGIT_W +: DIGIT_W]),
      .tc      (en_chain[g+1])
    );
  end

  assign term_cnt = en_chain[DIGITS];

  // R7
  tc_zero_chk: assert property (@(posedge clk) disable iff (!load_n)
    term_cnt |-> cnt_en && (count == '0));

  // R6
  full_wrap_chk: assert property (@(posedge clk) disable iff (!load_n)
    term_cnt |=> count == ALL_NINES);

  if (DIGITS >= 2) begin : g_carry_chk
    // R5
    carry_step_chk: assert property (@(posedge clk) disable iff (!load_n)
      cnt_en && (count[DIGIT_W-1:0] == '0) &&
      (count[2*DIGIT_W-1:DIGIT_W] != '0) && (count[2*DIGIT_W-1:DIGIT_W] <= DIGIT_TOP)
      |=> (count[DIGIT_W-1:0] == DIGIT_TOP) &&
          (count[2*DIGIT_W-1:DIGIT_W] == digit_t'($past(count[2*DIGIT_W-1:DIGIT_W]) - 1'b1)));

    // R5
    no_early_carry_chk: assert property (@(posedge clk) disable iff (!load_n)
      (count[DIGIT_W-1:0] != '0) |=> $stable(count[TOTAL_W-1:DIGIT_W]));
  end
endmodule

// File: tb/bcd_dncount_test.sv
`timescale 1ns/1ps
module bcd_dncount_test;
  localparam int DIGITS = 2;
  localparam int W = DIGITS * 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         load_n = 1'b0;
  logic         cnt_en = 1'b0;
  logic [W-1:0] preset = '0;
  logic [W-1:0] count;
  logic         term_cnt;

  int checks = 0;
  int errors = 0;
  int mdl[DIGITS];
  bit done = 1'b0;

  bcd_dncount #(.DIGITS(DIGITS)) uut (
    .clk      (clk),
    .load_n   (load_n),
    .cnt_en   (cnt_en),
    .preset   (preset),
    .count    (count),
    .term_cnt (term_cnt)
  );

  function automatic logic [W-1:0] mdl_vec();
    logic [W-1:0] v;
    for (int i = 0; i < DIGITS; i++) v[i*4 +: 4] = 4'(mdl[i]);
    return v;
  endfunction

  function automatic logic mdl_tc();
    logic z = 1'b1;
    for (int i = 0; i < DIGITS; i++) if (mdl[i] != 0) z = 1'b0;
    return cnt_en && z;
  endfunction

  task automatic mdl_edge();
    int  old[DIGITS];
    bit  carry;
    old = mdl;
    if (!load_n) begin
      for (int i = 0; i < DIGITS; i++) mdl[i] = int'(preset[i*4 +: 4]);
    end else if (cnt_en) begin
      carry = 1'b1;
      for (int i = 0; i < DIGITS; i++) begin
        if (carry) mdl[i] = (old[i] == 0 || old[i] > 9) ? 9 : old[i] - 1;
        carry = carry && (old[i] == 0);
      end
    end
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Called just after a falling edge: drive, check term_cnt, run one edge, check count.
  task automatic cyc(input logic ld, input logic en, input logic [W-1:0] pre, input string tag);
    load_n = ld;
    cnt_en = en;
    preset = pre;
    #1;
    check(term_cnt === mdl_tc(), "R7", int'(term_cnt), int'(mdl_tc()));
    @(posedge clk);
    mdl_edge();
    @(negedge clk);
    check(count === mdl_vec(), tag, int'(count), int'(mdl_vec()));
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R4: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DIGITS; i++) mdl[i] = 0;
    @(negedge clk);
    // R1: reset state via synchronous preset
    cyc(1'b0, 1'b0, 8'h29, "R1");
    check(count === 8'h29, "R1", int'(count), 'h29);

    // R5: 29 down to 20 then 19, one value per cycle
    for (int i = 0; i < 9; i++) cyc(1'b1, 1'b1, 8'h00, "R5");
    check(count === 8'h20, "R5", int'(count), 'h20);
    cyc(1'b1, 1'b1, 8'h00, "R5");
    check(count === 8'h19, "R5", int'(count), 'h19);
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, 8'h00, "R4");

    // R3: hold while disabled, preset ignored
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 8'h77, "R3");
    check(count === 8'h14, "R3", int'(count), 'h14);

    // R2: load pulse between edges is not seen
    load_n = 1'b0;
    preset = 8'h11;
    #2;
    load_n = 1'b1;
    cyc(1'b1, 1'b0, 8'h11, "R2");
    check(count === 8'h14, "R2", int'(count), 'h14);

    // R1: load wins over enable
    cyc(1'b0, 1'b1, 8'h00, "R1");
    check(count === 8'h00, "R1", int'(count), 'h00);
    // R7: no terminal count while disabled, then R6 wrap
    cyc(1'b1, 1'b0, 8'h00, "R7");
    check(term_cnt === 1'b0, "R7", int'(term_cnt), 0);
    cyc(1'b1, 1'b1, 8'h00, "R6");
    check(count === 8'h99, "R6", int'(count), 'h99);

    // R8: out-of-range digits
    cyc(1'b0, 1'b0, 8'h5C, "R1");
    cyc(1'b1, 1'b1, 8'h00, "R8");
    check(count === 8'h59, "R8", int'(count), 'h59);
    cyc(1'b0, 1'b0, 8'hF0, "R1");
    cyc(1'b1, 1'b1, 8'h00, "R8");
    check(count === 8'h99, "R8", int'(count), 'h99);

    // R4: full cycle from 99 back to 99
    cyc(1'b0, 1'b0, 8'h99, "R1");
    for (int i = 0; i < 100; i++) cyc(1'b1, 1'b1, 8'h00, "R4");
    check(count === 8'h99, "R4", int'(count), 'h99);

    // Random traffic against the model
    for (int i = 0; i < 400; i++)
      cyc(($urandom % 16) != 0, ($urandom % 4) != 0, W'($urandom), "R4");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule